// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits in front of a small NOR-style word array. It turns bus write cycles into command sequences and runs a simplified erase engine. Each bus write carries an 8-bit command code in the low byte of the data. One-write commands choose where later bus reads come from: the array, the status byte, the identifier area or the query area. Erasing takes a setup write followed by a confirm write. The confirm write either starts a fixed-length erase, or aborts and records an error in the status byte. A per-block protect input keeps chosen blocks out of any erase.

The array is split into `2**BLK_BITS` blocks of `2**OFS_BITS` 16-bit words. Reset loads every word with a known pattern, so the effect of an erase can be seen on the bus. Reads are synchronous. A read strobe samples the address at a clock edge, and the selected word shows on the read-data output after that edge. The output keeps that value until the next read strobe.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode with the engine idle. The status byte reads 80h. The word at flat address i holds FILL_BASE XOR i, where the flat address is {block, offset} with the block in the upper bits.
- R2: A read strobe sampled at a clock edge loads read data from the current source at that edge. Read data keeps its value while the read strobe is low. In array-read mode the source is the array word at the address.
- R3: Only wdata[7:0] is decoded and wdata[15:8] is ignored. When the engine is idle and no setup is pending, the codes act as follows. FFh selects array read. 70h selects status read, where reads at any address return {8'h00, status}. 90h selects identifier read. 98h selects query read. Any unknown code, including B0h, returns the controller to array read.
- R4: Identifier reads decode the two lowest address bits: 0 gives MANUF_ID, 1 gives DEVICE_ID, 2 gives the protect flag of the addressed block in bit 0, and 3 gives 0. Query reads decode the three lowest address bits: 0, 1 and 2 give 0051h, 0052h and 0059h; 3 gives the block count; 4 gives the words per block; 5 gives ERASE_CYCLES; 6 and 7 give 0.
- R5: 20h followed by D0h erases the block named by the confirm address. The engine is busy for exactly ERASE_CYCLES clock cycles, then every word of that block reads FFFFh and all other blocks are unchanged. Reads between the setup write and the confirm write return the status byte.
- R6: When the write after a 20h or 80h setup is anything other than D0h, status bits 4 and 5 are set. The array is not changed, the engine does not start, and the controller returns to array read.
- R7: A block-erase confirm that targets a protected block does not start the engine. It sets status bits 1 and 5, leaves the block unchanged, and selects status read.
- R8: 80h followed by D0h at any address erases every unprotected block and leaves protected blocks unchanged. When every block is protected, the command aborts as in R7.
- R9: While the engine is busy, every read returns the status byte, with bit 7 at 0, whatever the address. During that time B0h sets status bit 6 until the erase ends. Every other write, including 70h, has no effect.
- R10: When an erase ends, status bit 7 returns to 1, bit 6 clears, and the controller is in status-read mode.
- R11: Status bits 1, 4 and 5 stay set until 50h is written while the engine is idle and no setup is pending. 50h clears them and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | BLK_BITS+OFS_BITS | Word address {block, offset} |
| wdata_i | input | 16 | Write data; the command is in bits 7:0 |
| blk_prot_i | input | 2**BLK_BITS | Protect flag per block |
| rdata_o | output | 16 | Registered read data |

## Verification
The bench builds the block with four blocks of four words and an erase time of five cycles. With 16 words, every word can be compared against a model after each erase. With five cycles, the busy window can be counted read by read, and the bench can insert suspend and ignored writes at known cycles inside it. These small settings also put every identifier and query offset within reach. Aliasing above the decoded address bits can be checked with addresses in higher blocks.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
   localparam int unsigned WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [2:0] {
      MD_ARRAY      = 3'd0,
      MD_STATUS     = 3'd1,
      MD_IDENT      = 3'd2,
      MD_QUERY      = 3'd3,
      MD_BLK_SETUP  = 3'd4,
      MD_CHIP_SETUP = 3'd5
   } mode_e;

   localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
   localparam logic [7:0] OP_RD_STATUS = 8'h70;
   localparam logic [7:0] OP_IDENT     = 8'h90;
   localparam logic [7:0] OP_QUERY     = 8'h98;
   localparam logic [7:0] OP_BLK_ERASE = 8'h20;
   localparam logic [7:0] OP_CHIP_ERASE= 8'h80;
   localparam logic [7:0] OP_SUSPEND   = 8'hB0;
   localparam logic [7:0] OP_CONFIRM   = 8'hD0;
   localparam logic [7:0] OP_CLEAR     = 8'h50;

   localparam int unsigned SB_READY = 7;
   localparam int unsigned SB_SUSP  = 6;
   localparam int unsigned SB_ERASE = 5;
   localparam int unsigned SB_SEQ   = 4;
   localparam int unsigned SB_PROT  = 1;
endpackage

// File: rtl/flash_erase_timer.sv
`timescale 1ns/1ps
module flash_erase_timer #(
   parameter int unsigned CYCLES = 64,
   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_BITS = 3,
   localparam int unsigned NB = 1 << BLK_BITS
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [7:0]          op_i,
   input  logic [BLK_BITS-1:0] blk_i,
   input  logic [NB-1:0]       prot_i,
   input  logic                busy_i,
   input  logic                done_i,
   output mode_e               mode_o,
   output logic                start_o,
   output logic [NB-1:0]       wipe_mask_o,
   output logic [7:0]          status_o
);
   mode_e         mode_q, mode_d;
   logic          susp_q, susp_d;
   logic          e_erase_q, e_erase_d;
   logic          e_seq_q, e_seq_d;
   logic          e_prot_q, e_prot_d;
   logic [NB-1:0] mask_q, mask_d;
   logic [NB-1:0] target;

   always_comb begin
      target = (mode_q == MD_BLK_SETUP) ? ((NB'(1) << blk_i) & ~prot_i) : ~prot_i;
   end

   always_comb begin
      mode_d    = mode_q;
      susp_d    = susp_q;
      e_erase_d = e_erase_q;
      e_seq_d   = e_seq_q;
      e_prot_d  = e_prot_q;
      mask_d    = mask_q;
      start_o   = 1'b0;
      if (busy_i) begin
         if (done_i) begin
            mode_d = MD_STATUS;
            susp_d = 1'b0;
         end else if (wr_en_i && op_i == OP_SUSPEND) begin
            susp_d = 1'b1;
         end
      end else if (wr_en_i) begin
         if (mode_q == MD_BLK_SETUP || mode_q == MD_CHIP_SETUP) begin
            if (op_i != OP_CONFIRM) begin
               e_seq_d   = 1'b1;
               e_erase_d = 1'b1;
               mode_d    = MD_ARRAY;
            end else if (target == '0) begin
               e_prot_d  = 1'b1;
               e_erase_d = 1'b1;
               mode_d    = MD_STATUS;
            end else begin
               mask_d  = target;
               start_o = 1'b1;
               mode_d  = MD_STATUS;
            end
         end else begin
            case (op_i)
               OP_RD_ARRAY:   mode_d = MD_ARRAY;
               OP_RD_STATUS:  mode_d = MD_STATUS;
               OP_IDENT:      mode_d = MD_IDENT;
               OP_QUERY:      mode_d = MD_QUERY;
               OP_BLK_ERASE:  mode_d = MD_BLK_SETUP;
               OP_CHIP_ERASE: mode_d = MD_CHIP_SETUP;
               OP_CLEAR: begin
                  e_erase_d = 1'b0;
                  e_seq_d   = 1'b0;
                  e_prot_d  = 1'b0;
               end
               default:       mode_d = MD_ARRAY;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q    <= MD_ARRAY;
         susp_q    <= 1'b0;
         e_erase_q <= 1'b0;
         e_seq_q   <= 1'b0;
         e_prot_q  <= 1'b0;
         mask_q    <= '0;
      end else begin
         mode_q    <= mode_d;
         susp_q    <= susp_d;
         e_erase_q <= e_erase_d;
         e_seq_q   <= e_seq_d;
         e_prot_q  <= e_prot_d;
         mask_q    <= mask_d;
      end
   end

   assign mode_o      = mode_q;
   assign wipe_mask_o = mask_q;
   assign status_o    = {~busy_i, susp_q, e_erase_q, e_seq_q, 2'b00, e_prot_q, 1'b0};
endmodule

// File: rtl/flash_word_store.sv
`timescale 1ns/1ps
module flash_word_store
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_BITS  = 3,
   parameter int unsigned OFS_BITS  = 4,
   parameter word_t       FILL_BASE = 16'hA500,
   localparam int unsigned NB     = 1 << BLK_BITS,
   localparam int unsigned WPB    = 1 << OFS_BITS,
   localparam int unsigned ADDR_W = BLK_BITS + OFS_BITS,
   localparam int unsigned NW     = NB * WPB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NB-1:0]     wipe_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output word_t             rdata_o
);
   word_t flat_w [NW];

   for (genvar b = 0; b < NB; b++) begin : g_blk
      for (genvar w = 0; w < WPB; w++) begin : g_word
         localparam word_t INIT = FILL_BASE ^ word_t'(b * WPB + w);
         word_t cell_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)        cell_q <= INIT;
            else if (wipe_i[b]) cell_q <= '1;
         end
         assign flat_w[b * WPB + w] = cell_q;
      end
   end

   assign rdata_o = flat_w[raddr_i];
endmodule

// File: rtl/flash_read_port.sv
`timescale 1ns/1ps
module flash_read_port
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_BITS     = 3,
   parameter int unsigned OFS_BITS     = 4,
   parameter int unsigned ERASE_CYCLES = 64,
   parameter word_t       MANUF_ID     = 16'h0031,
   parameter word_t       DEVICE_ID    = 16'h7A44,
   localparam int unsigned NB     = 1 << BLK_BITS,
   localparam int unsigned WPB    = 1 << OFS_BITS,
   localparam int unsigned ADDR_W = BLK_BITS + OFS_BITS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  mode_e             mode_i,
   input  logic              busy_i,
   input  logic [7:0]        status_i,
   input  logic [NB-1:0]     prot_i,
   input  word_t             array_i,
   output word_t             rdata_o
);
   word_t ident_w, query_w, src_w, rdata_q;
   logic [BLK_BITS-1:0] blk_w;

   assign blk_w = addr_i[ADDR_W-1 -: BLK_BITS];

   always_comb begin
      case (addr_i[1:0])
         2'd0:    ident_w = MANUF_ID;
         2'd1:    ident_w = DEVICE_ID;
         2'd2:    ident_w = {15'd0, prot_i[blk_w]};
         default: ident_w = '0;
      endcase
   end

   always_comb begin
      case (addr_i[2:0])
         3'd0:    query_w = 16'h0051;
         3'd1:    query_w = 16'h0052;
         3'd2:    query_w = 16'h0059;
         3'd3:    query_w = 16'(NB);
         3'd4:    query_w = 16'(WPB);
         3'd5:    query_w = 16'(ERASE_CYCLES);
         default: query_w = '0;
      endcase
   end

   always_comb begin
      if (busy_i) src_w = {8'h00, status_i};
      else begin
         case (mode_i)
            MD_ARRAY: src_w = array_i;
            MD_IDENT: src_w = ident_w;
            MD_QUERY: src_w = query_w;
            default:  src_w = {8'h00, status_i};
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_en_i) rdata_q <= src_w;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_BITS     = 3,
   parameter int unsigned OFS_BITS     = 4,
   parameter int unsigned ERASE_CYCLES = 64,
   parameter word_t       MANUF_ID     = 16'h0031,
   parameter word_t       DEVICE_ID    = 16'h7A44,
   parameter word_t       FILL_BASE    = 16'hA500,
   localparam int unsigned NB     = 1 << BLK_BITS,
   localparam int unsigned ADDR_W = BLK_BITS + OFS_BITS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [15:0]       wdata_i,
   input  logic [NB-1:0]     blk_prot_i,
   output logic [15:0]       rdata_o
);
   if (BLK_BITS < 1 || BLK_BITS > 8) begin : g_chk_blk
      $error("BLK_BITS must lie in 1..8");
   end
   if (OFS_BITS < 2 || ADDR_W < 3 || ADDR_W > 12) begin : g_chk_ofs
      $error("OFS_BITS must be >= 2 and the address 3..12 bits wide");
   end
   if (ERASE_CYCLES < 1 || ERASE_CYCLES > 65535) begin : g_chk_cyc
      $error("ERASE_CYCLES must lie in 1..65535");
   end

   logic [7:0]          op_w;
   logic [BLK_BITS-1:0] blk_w;
   logic                busy_w, done_w, start_w;
   mode_e               mode_w;
   logic [NB-1:0]       mask_w, wipe_w;
   logic [7:0]          status_w;
   word_t               array_w;
   logic [7:0]          unused_hi_w;

   assign op_w        = wdata_i[7:0];
   assign unused_hi_w = wdata_i[15:8];
   assign blk_w       = addr_i[ADDR_W-1 -: BLK_BITS];
   assign wipe_w      = done_w ? mask_w : '0;

   flash_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
      .clk_i, .rst_ni, .start_i(start_w), .busy_o(busy_w), .done_o(done_w)
   );

   flash_cmd_fsm #(.BLK_BITS(BLK_BITS)) u_fsm (
      .clk_i, .rst_ni, .wr_en_i, .op_i(op_w), .blk_i(blk_w), .prot_i(blk_prot_i),
      .busy_i(busy_w), .done_i(done_w), .mode_o(mode_w), .start_o(start_w),
      .wipe_mask_o(mask_w), .status_o(status_w)
   );

   flash_word_store #(.BLK_BITS(BLK_BITS), .OFS_BITS(OFS_BITS), .FILL_BASE(FILL_BASE)) u_store (
      .clk_i, .rst_ni, .wipe_i(wipe_w), .raddr_i(addr_i), .rdata_o(array_w)
   );

   flash_read_port #(
      .BLK_BITS(BLK_BITS), .OFS_BITS(OFS_BITS), .ERASE_CYCLES(ERASE_CYCLES),
      .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID)
   ) u_rport (
      .clk_i, .rst_ni, .rd_en_i, .addr_i, .mode_i(mode_w), .busy_i(busy_w),
      .status_i(status_w), .prot_i(blk_prot_i), .array_i(array_w), .rdata_o(rdata_o)
   );
endmodule

// File: rtl/flash_cmd_ctrl_sva.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_sva
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_BITS     = 3,
   parameter int unsigned ERASE_CYCLES = 64,
   localparam int unsigned NB = 1 << BLK_BITS
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_en_i,
   input logic                rd_en_i,
   input logic [7:0]          op_w,
   input logic [BLK_BITS-1:0] blk_w,
   input logic [NB-1:0]       blk_prot_i,
   input mode_e               mode_w,
   input logic                busy_w,
   input logic                done_w,
   input logic [7:0]          status_w,
   input logic [15:0]         rdata_o
);
   logic [31:0] run_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     run_q <= '0;
      else if (busy_w) run_q <= run_q + 1;
      else             run_q <= '0;
   end

   a_r5_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_w) |-> run_q == ERASE_CYCLES);

   a_r9_busy_read_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && busy_w) |=> (rdata_o[15:8] == 8'h00 && !rdata_o[7]));

   a_r9_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_w && !done_w && wr_en_i && op_w != OP_SUSPEND) |=> ($stable(mode_w) && $stable(status_w)));

   a_r7_protected_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_w && wr_en_i && mode_w == MD_BLK_SETUP && op_w == OP_CONFIRM && blk_prot_i[blk_w])
      |=> (!busy_w && status_w[SB_PROT] && status_w[SB_ERASE] && mode_w == MD_STATUS));

   a_r6_bad_confirm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_w && wr_en_i && (mode_w == MD_BLK_SETUP || mode_w == MD_CHIP_SETUP) && op_w != OP_CONFIRM)
      |=> (status_w[SB_SEQ] && status_w[SB_ERASE] && mode_w == MD_ARRAY && !busy_w));

   a_r11_sticky_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_w[SB_ERASE] && !(wr_en_i && !busy_w && op_w == OP_CLEAR)) |=> status_w[SB_ERASE]);

   a_r10_end_to_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_w |=> (!busy_w && mode_w == MD_STATUS && status_w[SB_READY] && !status_w[SB_SUSP]));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_sva #(
   .BLK_BITS(BLK_BITS), .ERASE_CYCLES(ERASE_CYCLES)
) u_sva (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
   .op_w(op_w), .blk_w(blk_w), .blk_prot_i(blk_prot_i), .mode_w(mode_w),
   .busy_w(busy_w), .done_w(done_w), .status_w(status_w), .rdata_o(rdata_o)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
   localparam int unsigned BB = 2;
   localparam int unsigned OB = 2;
   localparam int unsigned NB = 1 << BB;
   localparam int unsigned WPB = 1 << OB;
   localparam int unsigned NW = NB * WPB;
   localparam int unsigned EC = 5;
   localparam logic [15:0] MID = 16'h0031;
   localparam logic [15:0] DID = 16'h7A44;
   localparam logic [15:0] FILL = 16'hA500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [BB+OB-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [NB-1:0] prot = '0;
   logic [15:0] rdata;

   int n_chk = 0, n_fail = 0;
   logic [15:0] model [NW];
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   flash_cmd_ctrl #(
      .BLK_BITS(BB), .OFS_BITS(OB), .ERASE_CYCLES(EC),
      .MANUF_ID(MID), .DEVICE_ID(DID), .FILL_BASE(FILL)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .blk_prot_i(prot), .rdata_o(rdata)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [7:0] op, input logic [BB+OB-1:0] a);
      wr_en = 1'b1; addr = a; wdata = {8'h3C, op};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [BB+OB-1:0] a, output logic [15:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic poll_ready(output int busy_reads, output logic [15:0] last);
      logic [15:0] d;
      busy_reads = 0;
      for (int i = 0; i < 200; i++) begin
         rd(4'(i), d);
         if (d[7]) break;
         busy_reads++;
      end
      last = d;
   endtask

   task automatic cmp_array(input string req);
      logic [15:0] d;
      for (int i = 0; i < NW; i++) begin
         rd(4'(i), d);
         chk(req, d, model[i]);
      end
   endtask

   task automatic t_reset();
      logic [15:0] d, hold;
      cmp_array("R1 reset array");
      rd(4'd6, hold);
      repeat (3) @(negedge clk);
      chk("R2 read data held", rdata, hold);
      wr(8'h70, 4'd0);
      rd(4'd9, d);  chk("R1 reset status", d, 16'h0080);
      wr(8'hFF, 4'd0);
      rd(4'd3, d);  chk("R2 array read", d, model[3]);
   endtask

   task automatic t_modes();
      logic [15:0] d;
      prot = 4'b0100;
      wr(8'h90, 4'd0);
      rd(4'd0, d);  chk("R4 ident manuf", d, MID);
      rd(4'd5, d);  chk("R4 ident device", d, DID);
      rd(4'd10, d); chk("R4 ident protected blk", d, 16'h0001);
      rd(4'd6, d);  chk("R4 ident unprotected blk", d, 16'h0000);
      rd(4'd15, d); chk("R4 ident offset 3", d, 16'h0000);
      wr(8'h98, 4'd0);
      rd(4'd0, d);  chk("R4 query 0", d, 16'h0051);
      rd(4'd1, d);  chk("R4 query 1", d, 16'h0052);
      rd(4'd2, d);  chk("R4 query 2", d, 16'h0059);
      rd(4'd11, d); chk("R4 query blocks", d, 16'(NB));
      rd(4'd4, d);  chk("R4 query words", d, 16'(WPB));
      rd(4'd13, d); chk("R4 query cycles", d, 16'(EC));
      rd(4'd6, d);  chk("R4 query 6", d, 16'h0000);
      wr(8'h42, 4'd0);
      rd(4'd7, d);  chk("R3 unknown code to array", d, model[7]);
      wr(8'h70, 4'd0);
      wr(8'hB0, 4'd0);
      rd(4'd8, d);  chk("R3 idle B0 to array", d, model[8]);
      prot = '0;
   endtask

   task automatic t_block_erase();
      logic [15:0] d;
      int n;
      wr(8'h20, 4'd5);
      rd(4'd1, d);  chk("R5 setup reads status", d, 16'h0080);
      wr(8'hD0, 4'd6);
      poll_ready(n, d);
      chk("R5 busy cycles", 16'(n), 16'(EC));
      chk("R10 ready after erase", d, 16'h0080);
      for (int i = 4; i < 8; i++) model[i] = 16'hFFFF;
      rd(4'd2, d);  chk("R10 status mode after erase", d, 16'h0080);
      wr(8'hFF, 4'd0);
      cmp_array("R5 block erased");
      // erase with suspend and ignored writes inside the busy window
      wr(8'h20, 4'd12);
      wr(8'hD0, 4'd13);
      rd(4'd14, d); chk("R9 busy read any addr", d, 16'h0000);
      wr(8'hFF, 4'd0);
      wr(8'hB0, 4'd0);
      rd(4'd3, d);  chk("R9 suspend bit", d, 16'h0040);
      wr(8'h70, 4'd0);
      poll_ready(n, d);
      chk("R10 suspend cleared at end", d, 16'h0080);
      for (int i = 12; i < 16; i++) model[i] = 16'hFFFF;
      rd(4'd1, d);  chk("R9 FF during busy ignored", d, 16'h0080);
      wr(8'hFF, 4'd0);
      cmp_array("R5 second block erased");
   endtask

   task automatic t_bad_confirm();
      logic [15:0] d;
      wr(8'h20, 4'd0);
      wr(8'h33, 4'd0);
      rd(4'd1, d);  chk("R6 array mode after bad confirm", d, model[1]);
      wr(8'h70, 4'd0);
      rd(4'd0, d);  chk("R6 status bits 4 5", d, 16'h00B0);
      wr(8'h90, 4'd0);
      wr(8'h70, 4'd0);
      rd(4'd0, d);  chk("R11 error sticky", d, 16'h00B0);
      wr(8'h50, 4'd0);
      rd(4'd0, d);  chk("R11 clear keeps status mode", d, 16'h0080);
      wr(8'h80, 4'd0);
      wr(8'hFF, 4'd0);
      wr(8'h70, 4'd0);
      rd(4'd0, d);  chk("R6 chip bad confirm", d, 16'h00B0);
      wr(8'h50, 4'd0);
      wr(8'hFF, 4'd0);
      cmp_array("R6 array unchanged");
   endtask

   task automatic t_protect();
      logic [15:0] d;
      prot = 4'b0101;
      wr(8'h20, 4'd0);
      wr(8'hD0, 4'd1);
      rd(4'd5, d);  chk("R7 abort no busy", d, 16'h00A2);
      wr(8'hFF, 4'd0);
      rd(4'd2, d);  chk("R7 block kept", d, model[2]);
      wr(8'h70, 4'd0);
      rd(4'd0, d);  chk("R11 prot error sticky", d, 16'h00A2);
      wr(8'h50, 4'd0);
      rd(4'd0, d);  chk("R11 cleared", d, 16'h0080);
   endtask

   task automatic t_chip();
      logic [15:0] d;
      int n;
      prot = 4'b0001;
      wr(8'h80, 4'd0);
      wr(8'hD0, 4'd9);
      poll_ready(n, d);
      chk("R8 chip busy cycles", 16'(n), 16'(EC));
      for (int i = 4; i < 16; i++) model[i] = 16'hFFFF;
      wr(8'hFF, 4'd0);
      cmp_array("R8 protected block kept");
      prot = 4'b1111;
      wr(8'h80, 4'd0);
      wr(8'hD0, 4'd0);
      rd(4'd0, d);  chk("R8 all protected abort", d, 16'h00A2);
      prot = 4'b0000;
      wr(8'h50, 4'd0);
      wr(8'h80, 4'd0);
      wr(8'hD0, 4'd0);
      poll_ready(n, d);
      for (int i = 0; i < 4; i++) model[i] = 16'hFFFF;
      wr(8'hFF, 4'd0);
      cmp_array("R8 full chip erase");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) model[i] = FILL ^ 16'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_block_erase();
      t_bad_confirm();
      t_protect();
      t_chip();
      done_flag = 1'b1;
      finish_run();
   end
endmodule